// File: doc/BRIEF.md
# Memory Port Bandwidth Monitor

This block watches the request and grant traffic of a memory controller arbiter and counts it over a time window. Every request pulse and every grant pulse is tallied in two total counters. In addition, each of four channels keeps its own grant counter. A channel counts only the grants that pass its two-level filter. The first level is a bitmask over the 32 major ports. One major port, number 23, is the shared device port. For a grant on that port the first level defers to a second bitmask over the 16 device sub-ports.

Software programs the monitor through a plain word-addressed register interface. Writes take effect on the clock edge. Reads are combinational from the address. When timer-bounded counting is selected and the programmed number of counting cycles has passed, the window-done flag rises and drives the interrupt output. From then on all counters freeze. Software clears the flag by writing the control word back with the flag bit set. That write also zeroes every counter, so a new window starts from zero.

The request and grant inputs are valid-only event streams. Each one is a single-cycle pulse, and the grant carries its port and sub-port tags. The monitor never applies back-pressure: every pulse is taken in the cycle it is presented, so the streams have no ready signal.

Top module: `bwm_monitor`

## Requirements
- R1: After reset, the control word, timer, all filter registers and all counters read zero, and `irq` is low.
- R2: Register map by word index. 0x20 is the control word: bit 31 is the global enable, bit 30 the window-done flag, bit 20 selects timer-bounded counting, and bits 3:0 enable channels 0 to 3. For channel c, index 0x21+2c holds the 32-bit major-port mask and 0x22+2c holds the 16-bit sub-port mask, whose upper bits read zero. 0x29 is the total request count, 0x2A the total grant count, and 0x2B+c the grant count of channel c. 0x2F is the timer. Unmapped indices read zero.
- R3: While the global enable is set and the done flag is clear, every `req_valid` pulse adds one to the request total and every `gnt_valid` pulse adds one to the grant total.
- R4: A grant on a port p other than 23 adds one to channel c exactly when bit p of that channel's major mask is set, the channel enable bit c is set and counting is active.
- R5: A grant on port 23 adds one to channel c only when major-mask bit 23 is set and bit s of the channel's sub-port mask is also set, where s is `gnt_sub`.
- R6: A channel whose masks are both zero counts nothing. With the global enable clear, or with a channel's enable bit clear, that counter does not change.
- R7: With timer mode on and a timer value N greater than zero, the done flag and `irq` rise after exactly N counting cycles following the control write. From then on every counter holds. A timer value of zero, or timer mode off, never ends the window.
- R8: A control write with bit 30 set clears the done flag and zeroes all counters. A control write with bit 31 clear also clears the done flag.
- R9: Counters saturate at all ones instead of wrapping.
- R10: Any write to a counter index sets that counter to zero, whatever the data. If an event arrives in the same cycle, the write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One request event this cycle |
| gnt_valid | input | 1 | One grant event this cycle |
| gnt_port | input | PORT_W | Major port tag of the grant |
| gnt_sub | input | SUB_W | Device sub-port tag of the grant |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register word index |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| irq | output | 1 | Window-done interrupt |

## Verification
The filter is tried with a full sweep of grants over all 32 ports and all 16 sub-ports. During the sweep, one channel passes plain ports only, one passes the device port with a sparse sub-port mask, one mixes plain ports with the device port under an all-ones sub-port mask, and one matches nothing. The per-channel totals therefore separate mask indexing, sub-port indexing and the device-port hand-off. Later sweeps with the global enable off, and then with a single channel disabled, show that the two gates are independent. A continuous request stream checks the exact window length, the freeze, the write-back clear, and saturation at the top of the counter. A counter write issued in the same cycle as an event checks that the write wins.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int A_CTRL  = 'h20;
  localparam int A_FILT0 = 'h21;
  localparam int A_CNT0  = 'h29;
  localparam int A_TIMER = 'h2F;
  localparam int B_EN    = 31;
  localparam int B_DONE  = 30;
  localparam int B_TMODE = 20;
endpackage

// File: rtl/bwm_sat_counter.sv
module bwm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (inc && (cnt != '1))    cnt <= cnt + 1'b1;
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !clr) |=> (cnt == '1));
  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/bwm_chan_filter.sv
module bwm_chan_filter #(
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int DEV_PORT = 23
) (
  input  logic                     valid,
  input  logic [PORT_W-1:0]        port,
  input  logic [SUB_W-1:0]         sub,
  input  logic [(1<<PORT_W)-1:0]   pmask,
  input  logic [(1<<SUB_W)-1:0]    smask,
  output logic                     hit
);
  logic is_dev;
  assign is_dev = (port == PORT_W'(DEV_PORT));
  assign hit = valid && pmask[port] && (!is_dev || smask[sub]);
endmodule

// File: rtl/bwm_window.sv
module bwm_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        tmode,
  input  logic [31:0] len,
  input  logic        restart,
  input  logic        ack,
  output logic        done
);
  logic [31:0] elapsed;
  logic        run;

  assign run = enable && tmode && !done && (len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      done    <= 1'b0;
    end else begin
      if (ack) done <= 1'b0;
      if (restart) begin
        elapsed <= '0;
      end else if (run) begin
        if (elapsed >= len - 32'd1) begin
          done    <= 1'b1;
          elapsed <= '0;
        end else begin
          elapsed <= elapsed + 32'd1;
        end
      end
    end
  end

  // R7, R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ack) |=> done);
  // R7
  rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(enable && tmode));
endmodule

// File: rtl/bwm_monitor.sv
module bwm_monitor
  import bwm_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int CNT_W    = 32,
  parameter int DEV_PORT = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                gnt_valid,
  input  logic [PORT_W-1:0]   gnt_port,
  input  logic [SUB_W-1:0]    gnt_sub,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                irq
);
  localparam int NPORT   = 1 << PORT_W;
  localparam int NSUB    = 1 << SUB_W;
  localparam int NUM_CNT = NUM_CH + 2;

  logic              en_q, tmode_q, done;
  logic [NUM_CH-1:0] chen_q;
  logic [31:0]       len_q;
  logic [NPORT-1:0]  pmask [NUM_CH];
  logic [NSUB-1:0]   smask [NUM_CH];
  logic [CNT_W-1:0]  cnt   [NUM_CNT];
  logic [NUM_CNT-1:0] inc_v;
  logic [NUM_CH-1:0] hit;
  logic              active, ctrl_wr, ack, clr_all;

  assign active  = en_q && !done;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
  assign ack     = ctrl_wr && (wdata[B_DONE] || !wdata[B_EN]);
  assign clr_all = ctrl_wr && wdata[B_DONE];
  assign irq     = done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      tmode_q <= 1'b0;
      chen_q  <= '0;
      len_q   <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        pmask[c] <= '0;
        smask[c] <= '0;
      end
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        en_q    <= wdata[B_EN];
        tmode_q <= wdata[B_TMODE];
        chen_q  <= wdata[NUM_CH-1:0];
      end
      if (addr == ADDR_W'(A_TIMER)) len_q <= wdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(A_FILT0 + 2*c))     pmask[c] <= wdata[NPORT-1:0];
        if (addr == ADDR_W'(A_FILT0 + 2*c + 1)) smask[c] <= wdata[NSUB-1:0];
      end
    end
  end

  bwm_window u_win (
    .clk(clk), .rst_n(rst_n), .enable(en_q), .tmode(tmode_q), .len(len_q),
    .restart(ctrl_wr), .ack(ack), .done(done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bwm_chan_filter #(.PORT_W(PORT_W), .SUB_W(SUB_W), .DEV_PORT(DEV_PORT)) u_flt (
      .valid(gnt_valid && active && chen_q[c]), .port(gnt_port), .sub(gnt_sub),
      .pmask(pmask[c]), .smask(smask[c]), .hit(hit[c])
    );

    // R5
    dev_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[c] && gnt_port == PORT_W'(DEV_PORT)) |-> smask[c][gnt_sub]);
    // R6
    hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |-> (en_q && chen_q[c] && gnt_valid));
  end

  always_comb begin
    inc_v[0] = req_valid && active;
    inc_v[1] = gnt_valid && active;
    for (int c = 0; c < NUM_CH; c++) inc_v[c+2] = hit[c];
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    bwm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_all || (wr_en && addr == ADDR_W'(A_CNT0 + k))),
      .inc(inc_v[k]), .cnt(cnt[k])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL)) begin
      rdata[B_EN]         = en_q;
      rdata[B_DONE]       = done;
      rdata[B_TMODE]      = tmode_q;
      rdata[NUM_CH-1:0]   = chen_q;
    end
    if (addr == ADDR_W'(A_TIMER)) rdata = len_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(A_FILT0 + 2*c))     rdata[NPORT-1:0] = pmask[c];
      if (addr == ADDR_W'(A_FILT0 + 2*c + 1)) rdata[NSUB-1:0]  = smask[c];
    end
    for (int k = 0; k < NUM_CNT; k++)
      if (addr == ADDR_W'(A_CNT0 + k)) rdata[CNT_W-1:0] = cnt[k];
  end

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> $stable(cnt[1]));
endmodule

// File: tb/sim_bwm_monitor.sv
module sim_bwm_monitor;
  localparam int CW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, gnt_valid = 0, wr_en = 0;
  logic [4:0] gnt_port = '0;
  logic [3:0] gnt_sub = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] bm [4];
  logic [15:0] bs [4];
  int exp_ch [4];

  always #4 clk = ~clk;

  bwm_monitor #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .gnt_valid(gnt_valid),
    .gnt_port(gnt_port), .gnt_sub(gnt_sub), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", rq, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic grant(int p, int s);
    @(negedge clk); gnt_valid = 1; gnt_port = 5'(p); gnt_sub = 4'(s);
    @(negedge clk); gnt_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8*200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    rd(8'h20, v); chk("R1 ctrl", v, 0);
    rd(8'h2F, v); chk("R1 timer", v, 0);
    rd(8'h21, v); chk("R1 pmask", v, 0);
    for (int k = 0; k < 6; k++) begin rd(8'(8'h29 + k), v); chk("R1 counter", v, 0); end
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 map and field positions
    wr(8'h2F, 32'h0000_1234); rd(8'h2F, v); chk("R2 timer rb", v, 32'h1234);
    wr(8'h20, 32'h0010_000A); rd(8'h20, v); chk("R2 ctrl rb", v, 32'h0010_000A);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R2 sub mask width", v, 32'h0000_FFFF);
    rd(8'h30, v); chk("R2 unmapped", v, 0);

    // filter sweep: R4 plain ports, R5 device port, R6 empty channel
    bm[0] = 32'h0000_00FF; bs[0] = 16'hFFFF;
    bm[1] = 32'h0080_0000; bs[1] = 16'h00A5;
    bm[2] = 32'hF0F0_0F0F; bs[2] = 16'hFFFF;
    bm[3] = 32'h0;         bs[3] = 16'h0;
    for (int c = 0; c < 4; c++) begin
      wr(8'(8'h21 + 2*c), bm[c]); wr(8'(8'h22 + 2*c), {16'h0, bs[c]});
    end
    wr(8'h2F, 0);
    wr(8'h20, 32'h8000_000F);
    for (int k = 0; k < 6; k++) wr(8'(8'h29 + k), 32'h55); // R10 any data zeroes
    for (int c = 0; c < 4; c++) exp_ch[c] = 0;
    for (int p = 0; p < 32; p++)
      for (int s = 0; s < 16; s++) begin
        @(negedge clk); gnt_valid = 1; gnt_port = 5'(p); gnt_sub = 4'(s);
        req_valid = (s % 2 == 0);
        for (int c = 0; c < 4; c++)
          if (bm[c][p] && (p != 23 || bs[c][s])) exp_ch[c]++;
      end
    @(negedge clk); gnt_valid = 0; req_valid = 0;
    rd(8'h29, v); chk("R3 req total", v, 256);
    rd(8'h2A, v); chk("R3 gnt total", v, 512);
    rd(8'h2B, v); chk("R4 ch0 plain ports", v, 32'(exp_ch[0]));
    rd(8'h2C, v); chk("R5 ch1 device subports", v, 32'(exp_ch[1]));
    rd(8'h2D, v); chk("R5 ch2 mixed", v, 32'(exp_ch[2]));
    rd(8'h2E, v); chk("R6 ch3 zero masks", v, 0);

    // R6 global enable off
    wr(8'h20, 32'h0000_000F);
    for (int s = 0; s < 16; s++) grant(0, s);
    rd(8'h2A, v); chk("R6 global off total", v, 512);
    rd(8'h2B, v); chk("R6 global off ch0", v, 32'(exp_ch[0]));
    // R6 channel 0 disabled only
    wr(8'h20, 32'h8000_000E);
    for (int s = 0; s < 16; s++) grant(0, s);
    rd(8'h2B, v); chk("R6 ch0 disabled", v, 32'(exp_ch[0]));
    rd(8'h2D, v); chk("R4 ch2 still on", v, 32'(exp_ch[2] + 16));
    rd(8'h2A, v); chk("R3 total after", v, 528);

    // R7 window length and freeze
    wr(8'h20, 32'h4000_0000);
    rd(8'h2A, v); chk("R8 clear zeroes", v, 0);
    wr(8'h2F, 20);
    req_valid = 1;
    wr(8'h20, 32'h8010_000F);
    idle(30);
    chk("R7 irq", {31'd0, irq}, 1);
    rd(8'h20, v); chk("R7 done bit", v, 32'hC010_000F);
    rd(8'h29, v); chk("R7 window count", v, 20);
    idle(5);
    rd(8'h29, v); chk("R7 frozen", v, 20);
    req_valid = 0;
    wr(8'h20, 32'hC010_000F);
    chk("R8 irq cleared", {31'd0, irq}, 0);
    rd(8'h29, v); chk("R8 counter zeroed", v, 0);
    idle(25);
    chk("R7 second window", {31'd0, irq}, 1);
    wr(8'h20, 32'h0);
    chk("R8 disable clears flag", {31'd0, irq}, 0);
    wr(8'h2F, 0);
    wr(8'h20, 32'h8010_000F);
    idle(50);
    chk("R7 zero timer never ends", {31'd0, irq}, 0);

    // R9 saturation
    wr(8'h20, 32'hC000_000F);
    req_valid = 1; idle(1100);
    rd(8'h29, v); chk("R9 saturate", v, 32'h3FF);
    // R10 write wins over concurrent event
    wr(8'h29, 32'h77);
    rd(8'h29, v); chk("R10 write wins", v, 0);
    req_valid = 0;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule